// File: doc/BRIEF.md
# Buffered parallel-in serial-out shifter

This block turns parallel words into a serial bit stream. It has two registers in series. A holding register takes a copy of the parallel input bus whenever the capture strobe is high. A shift register then takes its contents from the holding register on a parallel load. Because of this split, the next word can be captured while the current word is still shifting out. Both strobes are single-cycle clock enables in the one system clock domain. Load and clear take priority over shifting.

The serial output is the top stage of the shift register, so a freshly loaded word leaves most significant bit first. Bit 0 of the shift register refills from a serial input. Several instances can therefore be chained by wiring one instance's output to the next instance's serial input. Asserting load and clear together has no meaningful result. Inside this block that case resolves to a clear, and it sets a sticky error flag.

Top module: `piso_buffered_shifter`

## Requirements
- R1: A synchronous active-high reset, seen at a clock edge, sets the holding register, the shift register and the error flag to zero. After that edge the serial output is 0, and a load with no capture before it yields an all-zero word.
- R2: A clock edge with the capture strobe high copies the parallel input into the holding register. Capturing while a word shifts out leaves that word's bit stream unchanged.
- R3: A clock edge with the load input low (value 0) and the clear input high (value 1) copies the holding register into the shift register. This happens whatever the shift strobe is, and it repeats on every edge while load stays low.
- R4: A clock edge with the clear input low (value 0) sets every shift-register stage to 0, whatever the strobes, the serial input and the load input are.
- R5: A clock edge with the shift strobe high, load high and clear high moves stage i to stage i+1 for every i, and stage 0 takes the serial input.
- R6: The serial output is the highest stage (index WIDTH-1), so it shows bit WIDTH-1 of the loaded word in the cycle after the load, then lower bits after each shift.
- R7: If the capture strobe is high on the same edge as a load, the shift register takes the parallel input directly rather than the old holding value.
- R8: A clock edge with load and clear both low clears the shift register and sets the error flag. The flag then stays 1 until reset.
- R9: A clock edge with load high, clear high and the shift strobe low leaves the shift register unchanged, whatever the serial input and parallel input are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| parIn | input | WIDTH | Parallel word to capture |
| capStrobe | input | 1 | Capture enable for the holding register |
| shiftStrobe | input | 1 | Shift enable for the shift register |
| loadN | input | 1 | Active-low parallel load from the holding register |
| clearN | input | 1 | Active-low clear of the shift register |
| serIn | input | 1 | Serial input into stage 0 |
| serOut | output | 1 | Serial output, highest stage |
| conflictErr | output | 1 | Sticky flag: load and clear were asserted together |

## Verification
The bench builds the block with its default WIDTH of 8. At that width it can sweep every one of the 256 possible words through capture, load and a full eight-step shift-out. Two instances are chained serial output to serial input, which forms a 16-bit stream. This shows that the second instance receives the first one's bits in order after its own word. Directed sequences on the same width cover the priority cases: capture during shifting, load held with shift active, same-edge capture and load, clear against a set serial input, idle holding, and the load-plus-clear conflict.

// File: rtl/piso_pkg.sv
`timescale 1ns/1ps
package piso_pkg;
  // Decoded per-cycle actions handed from control to datapath
  typedef struct packed {
    logic captureEn;   // copy parallel input into holding register
    logic loadEn;      // shift register takes a parallel word
    logic loadFresh;   // parallel word comes straight from the input bus
    logic clearEn;     // shift register forced to zero
    logic shiftEn;     // shift one place toward the output
  } pisoCtrl_t;
endpackage

// File: rtl/piso_ctrl.sv
`timescale 1ns/1ps
module piso_ctrl
  import piso_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      capStrobe,
  input  logic      shiftStrobe,
  input  logic      loadN,
  input  logic      clearN,
  output pisoCtrl_t ctrl,
  output logic      conflictErr
);
  logic clearReq;
  logic loadReq;
  logic conflictNow;
  logic errQ;

  assign clearReq    = ~clearN;
  assign loadReq     = ~loadN;
  assign conflictNow = clearReq & loadReq;

  // Priority: clear, then load, then shift
  always_comb begin
    ctrl.captureEn = capStrobe;
    ctrl.clearEn   = clearReq;
    ctrl.loadEn    = loadReq & ~clearReq;
    ctrl.loadFresh = loadReq & ~clearReq & capStrobe;
    ctrl.shiftEn   = shiftStrobe & ~loadReq & ~clearReq;
  end

  always_ff @(posedge clk) begin
    if (rst)              errQ <= 1'b0;
    else if (conflictNow) errQ <= 1'b1;
  end

  assign conflictErr = errQ;
endmodule

// File: rtl/piso_datapath.sv
`timescale 1ns/1ps
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  pisoCtrl_t        ctrl,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic [WIDTH-1:0] storageQ,
  output logic [WIDTH-1:0] shiftQ
);
  logic [WIDTH-1:0] loadSrc;
  logic [WIDTH-1:0] nextShift;

  // Holding register
  always_ff @(posedge clk) begin
    if (rst)                 storageQ <= '0;
    else if (ctrl.captureEn) storageQ <= parIn;
  end

  assign loadSrc = ctrl.loadFresh ? parIn : storageQ;

  // One next-state mux per stage
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic prevBit;
    if (i == 0) begin : g_head
      assign prevBit = serIn;
    end else begin : g_body
      assign prevBit = shiftQ[i-1];
    end
    assign nextShift[i] = ctrl.clearEn ? 1'b0 :
                          ctrl.loadEn  ? loadSrc[i] :
                          ctrl.shiftEn ? prevBit :
                                         shiftQ[i];
  end

  always_ff @(posedge clk) begin
    if (rst) shiftQ <= '0;
    else     shiftQ <= nextShift;
  end
endmodule

// File: rtl/piso_buffered_shifter.sv
`timescale 1ns/1ps
module piso_buffered_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] parIn,
  input  logic             capStrobe,
  input  logic             shiftStrobe,
  input  logic             loadN,
  input  logic             clearN,
  input  logic             serIn,
  output logic             serOut,
  output logic             conflictErr
);
  localparam int MSB = WIDTH - 1;

  pisoCtrl_t        ctrl;
  logic [WIDTH-1:0] storageQ;
  logic [WIDTH-1:0] shiftQ;

  piso_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .capStrobe   (capStrobe),
    .shiftStrobe (shiftStrobe),
    .loadN       (loadN),
    .clearN      (clearN),
    .ctrl        (ctrl),
    .conflictErr (conflictErr)
  );

  piso_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .parIn    (parIn),
    .serIn    (serIn),
    .storageQ (storageQ),
    .shiftQ   (shiftQ)
  );

  assign serOut = shiftQ[MSB];
endmodule

// File: rtl/piso_checker.sv
`timescale 1ns/1ps
module piso_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] parIn,
  input logic             capStrobe,
  input logic             shiftStrobe,
  input logic             loadN,
  input logic             clearN,
  input logic             serIn,
  input logic             conflictErr,
  input logic [WIDTH-1:0] storageQ,
  input logic [WIDTH-1:0] shiftQ
);
  // R2
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    capStrobe |=> storageQ == $past(parIn));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (clearN && !loadN && !capStrobe) |=> shiftQ == $past(storageQ));

  // R7
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (clearN && !loadN && capStrobe) |=> shiftQ == $past(parIn));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    !clearN |=> shiftQ == '0);

  // R5
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    (loadN && clearN && shiftStrobe) |=>
      shiftQ == {$past(shiftQ[WIDTH-2:0]), $past(serIn)});

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (loadN && clearN && !shiftStrobe) |=> $stable(shiftQ));

  // R8
  conflict_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadN && !clearN) |=> conflictErr);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    conflictErr |=> conflictErr);
endmodule

bind piso_buffered_shifter piso_checker #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .parIn       (parIn),
  .capStrobe   (capStrobe),
  .shiftStrobe (shiftStrobe),
  .loadN       (loadN),
  .clearN      (clearN),
  .serIn       (serIn),
  .conflictErr (conflictErr),
  .storageQ    (storageQ),
  .shiftQ      (shiftQ)
);

// File: tb/piso_buffered_shifter_test.sv
`timescale 1ns/1ps
module piso_buffered_shifter_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] parA = '0;
  logic [W-1:0] parB = '0;
  logic         capStrobe = 1'b0;
  logic         shiftStrobe = 1'b0;
  logic         loadN = 1'b1;
  logic         clearN = 1'b1;
  logic         serIn = 1'b0;
  logic         serOutA, serOutB, errA, errB;

  int checks = 0;
  int failures = 0;

  // Bench reference state, updated from the requirement text
  logic [W-1:0] refStoreA = '0, refShiftA = '0;
  logic [W-1:0] refStoreB = '0, refShiftB = '0;
  logic         refErr = 1'b0;

  always #2.5 clk = ~clk;

  piso_buffered_shifter #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .parIn(parA), .capStrobe(capStrobe),
    .shiftStrobe(shiftStrobe), .loadN(loadN), .clearN(clearN),
    .serIn(serIn), .serOut(serOutA), .conflictErr(errA)
  );

  // Second stage of the cascade: serial input fed by the first
  piso_buffered_shifter #(.WIDTH(W)) uutB (
    .clk(clk), .rst(rst), .parIn(parB), .capStrobe(capStrobe),
    .shiftStrobe(shiftStrobe), .loadN(loadN), .clearN(clearN),
    .serIn(serOutA), .serOut(serOutB), .conflictErr(errB)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] nextShift(input logic [W-1:0] cur, input logic [W-1:0] store,
                                             input logic [W-1:0] din, input logic cap, input logic sh,
                                             input logic ldN, input logic clN, input logic sIn);
    if (!clN)     return '0;
    else if (!ldN) return cap ? din : store;
    else if (sh)  return {cur[W-2:0], sIn};
    else          return cur;
  endfunction

  // One clock cycle: drive at the falling edge, check at the next one
  task automatic cyc(input logic cap, input logic sh, input logic ldN, input logic clN,
                     input logic sIn, input logic [W-1:0] dA, input logic [W-1:0] dB,
                     input string tag);
    logic [W-1:0] nA, nB;
    capStrobe = cap; shiftStrobe = sh; loadN = ldN; clearN = clN;
    serIn = sIn; parA = dA; parB = dB;
    nA = nextShift(refShiftA, refStoreA, dA, cap, sh, ldN, clN, sIn);
    nB = nextShift(refShiftB, refStoreB, dB, cap, sh, ldN, clN, refShiftA[W-1]);
    if (cap) begin refStoreA = dA; refStoreB = dB; end
    refShiftA = nA; refShiftB = nB;
    if (!ldN && !clN) refErr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(serOutA, refShiftA[W-1], tag, "serOut first");
    chk(serOutB, refShiftB[W-1], tag, "serOut cascade");
    chk(errA, refErr, tag, "conflictErr");
  endtask

  task automatic doReset();
    rst = 1'b1; capStrobe = 0; shiftStrobe = 0; loadN = 1; clearN = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    refStoreA = '0; refShiftA = '0; refStoreB = '0; refShiftB = '0; refErr = 1'b0;
    chk(serOutA, 1'b0, "R1", "serOut after reset");
    chk(errA, 1'b0, "R1", "conflictErr after reset");
    chk(errB, 1'b0, "R1", "cascade conflictErr after reset");
  endtask

  initial begin : watchdog
    #1000000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    doReset();

    // R1: load with no capture since reset gives zeros
    cyc(0, 0, 0, 1, 1, 8'hFF, 8'hFF, "R1");
    for (int k = 0; k < W; k++) begin
      cyc(0, 1, 1, 1, 0, 8'hFF, 8'hFF, "R1");
      chk(serOutA, 1'b0, "R1", "zero word shifting");
    end

    // Sweep every word: capture, load, full shift-out through the cascade
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] wA, wB;
      wA = W'(v);
      wB = ~W'(v);
      cyc(1, 0, 1, 1, 0, wA, wB, "R2");
      cyc(0, 0, 0, 1, 0, 8'h00, 8'h00, "R3");
      chk(serOutA, wA[W-1], "R6", "first bit after load");
      for (int k = 1; k < W; k++) begin
        cyc(0, 1, 1, 1, wA[k-1] ^ 1'b1, 8'h00, 8'h00, "R5");
        chk(serOutA, wA[W-1-k], "R6", "msb-first order");
      end
      // R5: after eight shifts the first serial bit reaches the output
      cyc(0, 1, 1, 1, 1'b0, 8'h00, 8'h00, "R5");
      chk(serOutA, ~wA[0], "R5", "serial input reached output");
      // cascade: B has emitted its own word and now carries A's bits
      for (int k = 0; k < W; k++) begin
        cyc(0, 1, 1, 1, 1'b0, 8'h00, 8'h00, "R5");
      end
    end

    // R2: capture during shift-out does not disturb the stream
    cyc(1, 0, 1, 1, 0, 8'hC3, 8'h3C, "R2");
    cyc(0, 0, 0, 1, 0, 8'h00, 8'h00, "R3");
    cyc(0, 1, 1, 1, 0, 8'h00, 8'h00, "R2");
    cyc(1, 1, 1, 1, 0, 8'h5A, 8'hA5, "R2");
    chk(serOutA, 1'b0, "R2", "bit 5 of C3 while capturing");
    cyc(0, 1, 1, 1, 0, 8'h00, 8'h00, "R2");
    chk(serOutA, 1'b0, "R2", "bit 4 of C3");
    cyc(0, 0, 0, 1, 0, 8'h00, 8'h00, "R2");
    chk(serOutA, 1'b0, "R2", "new word msb");
    cyc(0, 1, 1, 1, 0, 8'h00, 8'h00, "R2");
    chk(serOutA, 1'b1, "R2", "new word bit 6");

    // R3: load overrides an active shift strobe, and repeats while held
    cyc(1, 0, 1, 1, 0, 8'hA5, 8'h00, "R3");
    cyc(0, 1, 0, 1, 1, 8'h00, 8'h00, "R3");
    chk(serOutA, 1'b1, "R3", "load beats shift");
    cyc(0, 1, 0, 1, 0, 8'h00, 8'h00, "R3");
    chk(serOutA, 1'b1, "R3", "load held");

    // R7: same-edge capture and load passes the bus straight through
    cyc(1, 0, 0, 1, 0, 8'h40, 8'h80, "R7");
    chk(serOutA, 1'b0, "R7", "fresh msb");
    chk(serOutB, 1'b1, "R7", "fresh msb cascade");
    cyc(0, 1, 1, 1, 0, 8'h00, 8'h00, "R7");
    chk(serOutA, 1'b1, "R7", "fresh bit 6");

    // R4: clear beats shift and a set serial input
    cyc(1, 0, 0, 1, 0, 8'hFF, 8'hFF, "R4");
    cyc(0, 1, 1, 0, 1, 8'hFF, 8'hFF, "R4");
    chk(serOutA, 1'b0, "R4", "cleared");
    for (int k = 0; k < W; k++) begin
      cyc(0, 1, 1, 1, 0, 8'h00, 8'h00, "R4");
      chk(serOutA, 1'b0, "R4", "all stages zero");
    end

    // R9: idle cycles hold the word despite changing inputs
    cyc(1, 0, 0, 1, 0, 8'h96, 8'h69, "R9");
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 1, 1, k[0], 8'hFF, 8'h00, "R9");
      chk(serOutA, 1'b1, "R9", "held msb");
    end
    cyc(0, 1, 1, 1, 0, 8'h00, 8'h00, "R9");
    chk(serOutA, 1'b0, "R9", "bit 6 after hold");

    // R8: load and clear together clear the register and stick the flag
    cyc(1, 0, 1, 1, 0, 8'hFF, 8'hFF, "R8");
    cyc(0, 0, 0, 0, 1, 8'h00, 8'h00, "R8");
    chk(serOutA, 1'b0, "R8", "clear wins");
    chk(errA, 1'b1, "R8", "flag set");
    cyc(0, 0, 0, 1, 0, 8'h00, 8'h00, "R8");
    cyc(0, 1, 1, 1, 0, 8'h00, 8'h00, "R8");
    chk(errA, 1'b1, "R8", "flag sticky");
    chk(errB, 1'b1, "R8", "flag sticky cascade");
    doReset();
    chk(errA, 1'b0, "R1", "flag cleared by reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule